// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Block

This block is the software-visible register file of a simple Ethernet MAC. It sits on a 32-bit bus that is addressed in words and has separate read and write strobes. It holds the operating mode, the interrupt event flags and their enables, and the frame length limits. It also holds the number of transmit descriptors, the station address and a set of plain storage words for PHY management and hash filtering. The frame datapath is not part of the block. That datapath reads the decoded configuration from output ports and reports three kinds of events through single-cycle pulses: frame sent, frame received, and received frame dropped for lack of a buffer.

The block also tracks the datapath's position in a descriptor table of 128 entries, which transmit and receive share. Transmit owns the first entries and receive owns the rest. A software reset bit in the mode word clears the event state and both table positions. It leaves every configuration word untouched. A single level interrupt line is raised when any enabled event flag is set.

Top module: `emac_csr_block`

## Requirements
- R1: After reset, the mode word (word address 0x00) reads 0x0000A000. The length word (0x06) reads 0x00400600, the descriptor count (0x08) reads 64, every other word reads 0, and irqOut is low.
- R2: Mode word bit 0 drives rxEnable, bit 1 drives txEnable, bit 5 drives promiscOn and bit 11 drives macSoftRst. The mode word stores bits 15:0.
- R3: The event flags word (0x01) has bit 0 for frame sent (evTxDone), bit 2 for frame received (evRxDone) and bit 4 for frame dropped (evRxDrop). A pulse sets its bit at the next edge. All other bits read 0.
- R4: Writing the event flags word clears each flag whose data bit is 1. An event arriving in the same cycle as the clearing write leaves its flag set.
- R5: The enable word (0x02) stores bits 0, 2 and 4 only. irqOut is a register that goes high one cycle after any flag is both set and enabled, and goes low one cycle after none is.
- R6: While mode bit 11 is 1, the event flags and both descriptor positions are held at 0 and incoming events are ignored. All configuration words keep their values.
- R7: The length word stores the minimum frame length in bits 31:16 (minFrameLen) and the maximum in bits 15:0 (maxFrameLen).
- R8: A write of more than 128 to the descriptor count word stores 128. Smaller values are stored as written.
- R9: Address word A (0x10, 32 bits) and address word B (0x11, bits 15:0) form stationAddr = {B[15:0], A}. Byte 0 of the address is stationAddr[47:40], and byte 5 is the least significant byte of word A.
- R10: Storage words: PHY command at 0x0B (bits 2:0), PHY address at 0x0C (register field 12:8, PHY field 4:0), PHY write data at 0x0D (bits 15:0), PHY read data at 0x0E (bits 15:0), PHY status at 0x0F (link-fail in bit 0), hash words at 0x12 and 0x13 (32 bits each). Unstored bits read 0.
- R11: Reads of any other word address return 0, and writes to them change nothing.
- R12: busRdata carries the read value in the cycle after busRd is sampled and is 0 in all other cycles.
- R13: txDescPtr starts at 0, steps on each evTxDone and wraps to 0 at the descriptor count. rxDescPtr starts at the count, steps on each evRxDone and wraps back to the count at 128. When the count is 0 or 128, the matching pointer does not move. evRxDrop does not move either pointer. Writing the count word resets both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the read strobe |
| evTxDone | input | 1 | Pulse: frame transmitted |
| evRxDone | input | 1 | Pulse: frame received |
| evRxDrop | input | 1 | Pulse: received frame dropped |
| irqOut | output | 1 | Level interrupt |
| rxEnable | output | 1 | Receive enable |
| txEnable | output | 1 | Transmit enable |
| promiscOn | output | 1 | Accept all destination addresses |
| macSoftRst | output | 1 | Software reset in force |
| minFrameLen | output | 16 | Minimum frame length |
| maxFrameLen | output | 16 | Maximum frame length |
| txDescCount | output | 8 | Number of transmit descriptors, 0 to 128 |
| txDescPtr | output | 8 | Current transmit descriptor |
| rxDescPtr | output | 8 | Current receive descriptor (absolute index) |
| stationAddr | output | 48 | Station address, byte 0 in the top byte |

## Verification
Bus writes, event pulses and pointer steps take effect at the first clock edge after they are driven. Read data appears one edge after the read strobe, and irqOut follows an event or a clearing write by two edges. The bench drives every stimulus on the falling edge and holds it across exactly one rising edge. It samples read data at the next falling edge and samples irqOut one falling edge later. It also samples irqOut at the intermediate falling edge, to confirm the line has not moved early. Pointer outputs and decoded configuration outputs are sampled at the falling edge that follows the rising edge which stores them.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int DESC_TOTAL = 128;
  localparam int PTR_W      = $clog2(DESC_TOTAL + 1);
  localparam int NUM_EV     = 3;
  localparam int MAC_W      = 48;
  localparam int HALF_W     = DATA_W / 2;

  // Position of each event flag inside the flags/enable words.
  localparam int EV_TX   = 0;
  localparam int EV_RX   = 1;
  localparam int EV_DROP = 2;
  localparam int unsigned EV_POS [NUM_EV] = '{0, 2, 4};

  localparam int MODE_RX_BIT  = 0;
  localparam int MODE_TX_BIT  = 1;
  localparam int MODE_PRO_BIT = 5;
  localparam int MODE_RST_BIT = 11;

  localparam logic [HALF_W-1:0] MODE_INIT    = 16'hA000;
  localparam logic [DATA_W-1:0] PKTLEN_INIT  = 32'h0040_0600;
  localparam logic [PTR_W-1:0]  TXCOUNT_INIT = PTR_W'(64);

  localparam logic [ADDR_W-1:0] A_MODE    = 8'h00;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 8'h01;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 8'h02;
  localparam logic [ADDR_W-1:0] A_PKTLEN  = 8'h06;
  localparam logic [ADDR_W-1:0] A_TXCOUNT = 8'h08;
  localparam logic [ADDR_W-1:0] A_PHYCMD  = 8'h0B;
  localparam logic [ADDR_W-1:0] A_PHYADR  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_PHYWD   = 8'h0D;
  localparam logic [ADDR_W-1:0] A_PHYRD   = 8'h0E;
  localparam logic [ADDR_W-1:0] A_PHYST   = 8'h0F;
  localparam logic [ADDR_W-1:0] A_ADDRA   = 8'h10;
  localparam logic [ADDR_W-1:0] A_ADDRB   = 8'h11;
  localparam logic [ADDR_W-1:0] A_HASH0   = 8'h12;
  localparam logic [ADDR_W-1:0] A_HASH1   = 8'h13;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_FLAGS, SEL_ENABLE, SEL_PKTLEN, SEL_TXCOUNT,
    SEL_PHYCMD, SEL_PHYADR, SEL_PHYWD, SEL_PHYRD, SEL_PHYST,
    SEL_ADDRA, SEL_ADDRB, SEL_HASH0, SEL_HASH1
  } rd_sel_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrFlags;
    logic    wrEnable;
    logic    wrPktLen;
    logic    wrTxCount;
    logic    wrPhyCmd;
    logic    wrPhyAdr;
    logic    wrPhyWd;
    logic    wrPhyRd;
    logic    wrPhySt;
    logic    wrAddrA;
    logic    wrAddrB;
    logic    wrHash0;
    logic    wrHash1;
    logic    rdEn;
    rd_sel_e rdSel;
  } csr_strobe_t;
endpackage

// File: rtl/emac_csr_ctrl.sv
module emac_csr_ctrl
  import emac_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output csr_strobe_t       stb
);
  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    if (busWr) begin
      unique case (busAddr)
        A_MODE:    stb.wrMode    = 1'b1;
        A_FLAGS:   stb.wrFlags   = 1'b1;
        A_ENABLE:  stb.wrEnable  = 1'b1;
        A_PKTLEN:  stb.wrPktLen  = 1'b1;
        A_TXCOUNT: stb.wrTxCount = 1'b1;
        A_PHYCMD:  stb.wrPhyCmd  = 1'b1;
        A_PHYADR:  stb.wrPhyAdr  = 1'b1;
        A_PHYWD:   stb.wrPhyWd   = 1'b1;
        A_PHYRD:   stb.wrPhyRd   = 1'b1;
        A_PHYST:   stb.wrPhySt   = 1'b1;
        A_ADDRA:   stb.wrAddrA   = 1'b1;
        A_ADDRB:   stb.wrAddrB   = 1'b1;
        A_HASH0:   stb.wrHash0   = 1'b1;
        A_HASH1:   stb.wrHash1   = 1'b1;
        default:   ;
      endcase
    end
    if (busRd) begin
      stb.rdEn = 1'b1;
      unique case (busAddr)
        A_MODE:    stb.rdSel = SEL_MODE;
        A_FLAGS:   stb.rdSel = SEL_FLAGS;
        A_ENABLE:  stb.rdSel = SEL_ENABLE;
        A_PKTLEN:  stb.rdSel = SEL_PKTLEN;
        A_TXCOUNT: stb.rdSel = SEL_TXCOUNT;
        A_PHYCMD:  stb.rdSel = SEL_PHYCMD;
        A_PHYADR:  stb.rdSel = SEL_PHYADR;
        A_PHYWD:   stb.rdSel = SEL_PHYWD;
        A_PHYRD:   stb.rdSel = SEL_PHYRD;
        A_PHYST:   stb.rdSel = SEL_PHYST;
        A_ADDRA:   stb.rdSel = SEL_ADDRA;
        A_ADDRB:   stb.rdSel = SEL_ADDRB;
        A_HASH0:   stb.rdSel = SEL_HASH0;
        A_HASH1:   stb.rdSel = SEL_HASH1;
        default:   stb.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/emac_csr_dp.sv
module emac_csr_dp
  import emac_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  csr_strobe_t        stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_EV-1:0]  evVec,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic [HALF_W-1:0]  modeReg,
  output logic [NUM_EV-1:0]  srcFlags,
  output logic [NUM_EV-1:0]  maskFlags,
  output logic [HALF_W-1:0]  minLen,
  output logic [HALF_W-1:0]  maxLen,
  output logic [PTR_W-1:0]   txCount,
  output logic [MAC_W-1:0]   stationAddr
);
  localparam logic [DATA_W-1:0] COUNT_CAP = DATA_W'(DESC_TOTAL);

  logic [DATA_W-1:0] pktLen;
  logic [2:0]        phyCmd;
  logic [4:0]        phyRegField;
  logic [4:0]        phyDevField;
  logic [HALF_W-1:0] phyWd;
  logic [HALF_W-1:0] phyRd;
  logic              linkFail;
  logic [DATA_W-1:0] addrA;
  logic [HALF_W-1:0] addrB;
  logic [DATA_W-1:0] hash0;
  logic [DATA_W-1:0] hash1;
  logic [NUM_EV-1:0] srcNext;
  logic [NUM_EV-1:0] wrBits;
  logic [NUM_EV-1:0] enBits;
  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] maskWord;
  logic [DATA_W-1:0] rdMux;
  logic              softRst;

  assign softRst = modeReg[MODE_RST_BIT];

  // Gather the sparse event bit positions of the write data and
  // scatter the flag/enable vectors back into bus words.
  always_comb begin
    srcWord  = '0;
    maskWord = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      wrBits[i]          = wrData[EV_POS[i]];
      srcWord[EV_POS[i]]  = srcFlags[i];
      maskWord[EV_POS[i]] = maskFlags[i];
    end
  end

  // Event pulses win over a clearing write in the same cycle.
  always_comb begin
    for (int i = 0; i < NUM_EV; i++) begin
      if (softRst)                      srcNext[i] = 1'b0;
      else if (evVec[i])                srcNext[i] = 1'b1;
      else if (stb.wrFlags && wrBits[i]) srcNext[i] = 1'b0;
      else                              srcNext[i] = srcFlags[i];
    end
    enBits = stb.wrEnable ? wrBits : maskFlags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcFlags  <= '0;
      maskFlags <= '0;
      irqOut    <= 1'b0;
    end else begin
      srcFlags  <= srcNext;
      maskFlags <= enBits;
      irqOut    <= |(srcFlags & maskFlags);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg     <= MODE_INIT;
      pktLen      <= PKTLEN_INIT;
      txCount     <= TXCOUNT_INIT;
      phyCmd      <= '0;
      phyRegField <= '0;
      phyDevField <= '0;
      phyWd       <= '0;
      phyRd       <= '0;
      linkFail    <= 1'b0;
      addrA       <= '0;
      addrB       <= '0;
      hash0       <= '0;
      hash1       <= '0;
    end else begin
      if (stb.wrMode)   modeReg <= wrData[HALF_W-1:0];
      if (stb.wrPktLen) pktLen  <= wrData;
      if (stb.wrTxCount) begin
        if (wrData > COUNT_CAP) txCount <= PTR_W'(DESC_TOTAL);
        else                    txCount <= wrData[PTR_W-1:0];
      end
      if (stb.wrPhyCmd) phyCmd <= wrData[2:0];
      if (stb.wrPhyAdr) begin
        phyRegField <= wrData[12:8];
        phyDevField <= wrData[4:0];
      end
      if (stb.wrPhyWd)  phyWd    <= wrData[HALF_W-1:0];
      if (stb.wrPhyRd)  phyRd    <= wrData[HALF_W-1:0];
      if (stb.wrPhySt)  linkFail <= wrData[0];
      if (stb.wrAddrA)  addrA    <= wrData;
      if (stb.wrAddrB)  addrB    <= wrData[HALF_W-1:0];
      if (stb.wrHash0)  hash0    <= wrData;
      if (stb.wrHash1)  hash1    <= wrData;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_MODE:    rdMux = {{HALF_W{1'b0}}, modeReg};
      SEL_FLAGS:   rdMux = srcWord;
      SEL_ENABLE:  rdMux = maskWord;
      SEL_PKTLEN:  rdMux = pktLen;
      SEL_TXCOUNT: rdMux = {{(DATA_W-PTR_W){1'b0}}, txCount};
      SEL_PHYCMD:  rdMux = {29'b0, phyCmd};
      SEL_PHYADR:  rdMux = {19'b0, phyRegField, 3'b0, phyDevField};
      SEL_PHYWD:   rdMux = {{HALF_W{1'b0}}, phyWd};
      SEL_PHYRD:   rdMux = {{HALF_W{1'b0}}, phyRd};
      SEL_PHYST:   rdMux = {31'b0, linkFail};
      SEL_ADDRA:   rdMux = addrA;
      SEL_ADDRB:   rdMux = {{HALF_W{1'b0}}, addrB};
      SEL_HASH0:   rdMux = hash0;
      SEL_HASH1:   rdMux = hash1;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rdEn ? rdMux : '0;
  end

  assign minLen      = pktLen[DATA_W-1:HALF_W];
  assign maxLen      = pktLen[HALF_W-1:0];
  assign stationAddr = {addrB, addrA};
endmodule

// File: rtl/emac_csr_descptr.sv
module emac_csr_descptr
  import emac_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             clrPtrs,
  input  logic [PTR_W-1:0] txCount,
  input  logic             evTx,
  input  logic             evRx,
  output logic [PTR_W-1:0] txPtr,
  output logic [PTR_W-1:0] rxPtr
);
  localparam logic [PTR_W-1:0] TOTAL = PTR_W'(DESC_TOTAL);

  logic [PTR_W-1:0] rxOff;
  logic [PTR_W-1:0] rxRegion;
  logic [PTR_W-1:0] txStep;
  logic [PTR_W-1:0] rxStep;

  assign rxRegion = TOTAL - txCount;
  assign txStep   = txPtr + 1'b1;
  assign rxStep   = rxOff + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPtr <= '0;
      rxOff <= '0;
    end else if (softRst || clrPtrs) begin
      txPtr <= '0;
      rxOff <= '0;
    end else begin
      if (evTx) txPtr <= (txCount == '0 || txStep >= txCount)  ? '0 : txStep;
      if (evRx) rxOff <= (rxRegion == '0 || rxStep >= rxRegion) ? '0 : rxStep;
    end
  end

  assign rxPtr = txCount + rxOff;
endmodule

// File: rtl/emac_csr_block.sv
module emac_csr_block
  import emac_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              evTxDone,
  input  logic              evRxDone,
  input  logic              evRxDrop,
  output logic              irqOut,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              promiscOn,
  output logic              macSoftRst,
  output logic [HALF_W-1:0] minFrameLen,
  output logic [HALF_W-1:0] maxFrameLen,
  output logic [PTR_W-1:0]  txDescCount,
  output logic [PTR_W-1:0]  txDescPtr,
  output logic [PTR_W-1:0]  rxDescPtr,
  output logic [MAC_W-1:0]  stationAddr
);
  csr_strobe_t       stb;
  logic [HALF_W-1:0] modeReg;
  logic [NUM_EV-1:0] srcFlags;
  logic [NUM_EV-1:0] maskFlags;
  logic [NUM_EV-1:0] evVec;

  always_comb begin
    evVec          = '0;
    evVec[EV_TX]   = evTxDone;
    evVec[EV_RX]   = evRxDone;
    evVec[EV_DROP] = evRxDrop;
  end

  emac_csr_ctrl i_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  emac_csr_dp i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (busWdata),
    .evVec       (evVec),
    .rdData      (busRdata),
    .irqOut      (irqOut),
    .modeReg     (modeReg),
    .srcFlags    (srcFlags),
    .maskFlags   (maskFlags),
    .minLen      (minFrameLen),
    .maxLen      (maxFrameLen),
    .txCount     (txDescCount),
    .stationAddr (stationAddr)
  );

  emac_csr_descptr i_ptr (
    .clk     (clk),
    .rstN    (rstN),
    .softRst (macSoftRst),
    .clrPtrs (stb.wrTxCount),
    .txCount (txDescCount),
    .evTx    (evTxDone),
    .evRx    (evRxDone),
    .txPtr   (txDescPtr),
    .rxPtr   (rxDescPtr)
  );

  assign rxEnable   = modeReg[MODE_RX_BIT];
  assign txEnable   = modeReg[MODE_TX_BIT];
  assign promiscOn  = modeReg[MODE_PRO_BIT];
  assign macSoftRst = modeReg[MODE_RST_BIT];
endmodule

// File: rtl/emac_csr_chk.sv
module emac_csr_chk
  import emac_csr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              evTxDone,
  input logic              evRxDone,
  input logic              evRxDrop,
  input logic              irqOut,
  input logic              macSoftRst,
  input logic [NUM_EV-1:0] srcFlags,
  input logic [NUM_EV-1:0] maskFlags,
  input logic [PTR_W-1:0]  txDescCount,
  input logic [PTR_W-1:0]  txDescPtr
);
  // R3 / R4: an event pulse always leaves its flag set
  a_r3_tx_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evTxDone && !macSoftRst) |=> srcFlags[EV_TX]);
  a_r3_rx_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evRxDone && !macSoftRst) |=> srcFlags[EV_RX]);
  a_r3_drop_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evRxDrop && !macSoftRst) |=> srcFlags[EV_DROP]);

  // R4: a one written to the received-frame flag clears it
  a_r4_clear_rx: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_FLAGS && busWdata[2] && !evRxDone) |=> !srcFlags[EV_RX]);

  // R5: an enabled pending flag raises the line one cycle later
  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    ((srcFlags & maskFlags) != '0) |=> irqOut);

  // R6: software reset clears event state and transmit position
  a_r6_soft_clear: assert property (@(posedge clk) disable iff (!rstN)
    macSoftRst |=> (srcFlags == '0 && txDescPtr == '0));

  // R8: stored count never exceeds the table size
  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    txDescCount <= PTR_W'(DESC_TOTAL));

  // R12: no read strobe, no read data
  a_r12_rdata_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> busRdata == '0);

  // R13: transmit position stays inside the transmit region
  a_r13_tx_range: assert property (@(posedge clk) disable iff (!rstN)
    (txDescCount == '0) ? (txDescPtr == '0) : (txDescPtr < txDescCount));
endmodule

bind emac_csr_block emac_csr_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWr       (busWr),
  .busRd       (busRd),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .evTxDone    (evTxDone),
  .evRxDone    (evRxDone),
  .evRxDrop    (evRxDrop),
  .irqOut      (irqOut),
  .macSoftRst  (macSoftRst),
  .srcFlags    (srcFlags),
  .maskFlags   (maskFlags),
  .txDescCount (txDescCount),
  .txDescPtr   (txDescPtr)
);

// File: tb/test_emac_csr_block.sv
`timescale 1ns/1ps
module test_emac_csr_block;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evTxDone = 1'b0;
  logic        evRxDone = 1'b0;
  logic        evRxDrop = 1'b0;
  logic        irqOut, rxEnable, txEnable, promiscOn, macSoftRst;
  logic [15:0] minFrameLen, maxFrameLen;
  logic [7:0]  txDescCount, txDescPtr, rxDescPtr;
  logic [47:0] stationAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  emac_csr_block i_emac_csr_block (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .evTxDone(evTxDone),
    .evRxDone(evRxDone), .evRxDrop(evRxDrop), .irqOut(irqOut),
    .rxEnable(rxEnable), .txEnable(txEnable), .promiscOn(promiscOn),
    .macSoftRst(macSoftRst), .minFrameLen(minFrameLen), .maxFrameLen(maxFrameLen),
    .txDescCount(txDescCount), .txDescPtr(txDescPtr), .rxDescPtr(rxDescPtr),
    .stationAddr(stationAddr)
  );

  typedef struct packed {
    logic        isRead;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'h0, 32'h0000A000, 8'd1},   // R1 mode
    '{1'b1, 8'h06, 32'h0, 32'h00400600, 8'd1},   // R1 length
    '{1'b1, 8'h08, 32'h0, 32'h00000040, 8'd1},   // R1 count
    '{1'b1, 8'h01, 32'h0, 32'h0,        8'd1},   // R1 flags
    '{1'b1, 8'h10, 32'h0, 32'h0,        8'd1},   // R1 address
    '{1'b0, 8'h08, 32'hC8, 32'h0,       8'd8},   // R8 200
    '{1'b1, 8'h08, 32'h0, 32'h80,       8'd8},
    '{1'b0, 8'h08, 32'h81, 32'h0,       8'd8},   // R8 129
    '{1'b1, 8'h08, 32'h0, 32'h80,       8'd8},
    '{1'b0, 8'h08, 32'h80, 32'h0,       8'd8},   // R8 exactly 128
    '{1'b1, 8'h08, 32'h0, 32'h80,       8'd8},
    '{1'b0, 8'h08, 32'h1_0000_005, 32'h0, 8'd8}, // R8 large value
    '{1'b1, 8'h08, 32'h0, 32'h80,       8'd8},
    '{1'b0, 8'h08, 32'h5, 32'h0,        8'd8},
    '{1'b1, 8'h08, 32'h0, 32'h5,        8'd8},
    '{1'b0, 8'h0C, 32'hFFFFFFFF, 32'h0, 8'd10},  // R10 phy address fields
    '{1'b1, 8'h0C, 32'h0, 32'h00001F1F, 8'd10},
    '{1'b0, 8'h0D, 32'h1234ABCD, 32'h0, 8'd10},
    '{1'b1, 8'h0D, 32'h0, 32'h0000ABCD, 8'd10},
    '{1'b0, 8'h0E, 32'h5A5AFFFF, 32'h0, 8'd10},
    '{1'b1, 8'h0E, 32'h0, 32'h0000FFFF, 8'd10},
    '{1'b0, 8'h12, 32'hDEADBEEF, 32'h0, 8'd10},
    '{1'b1, 8'h12, 32'h0, 32'hDEADBEEF, 8'd10},
    '{1'b1, 8'h13, 32'h0, 32'h0,        8'd10},
    '{1'b0, 8'h0B, 32'hFF, 32'h0,       8'd10},
    '{1'b1, 8'h0B, 32'h0, 32'h7,        8'd10},
    '{1'b0, 8'h0F, 32'h3, 32'h0,        8'd10},
    '{1'b1, 8'h0F, 32'h0, 32'h1,        8'd10},
    '{1'b0, 8'h05, 32'hFFFFFFFF, 32'h0, 8'd11},  // R11 hole
    '{1'b1, 8'h05, 32'h0, 32'h0,        8'd11},
    '{1'b1, 8'h3F, 32'h0, 32'h0,        8'd11},
    '{1'b1, 8'h00, 32'h0, 32'h0000A000, 8'd11},
    '{1'b0, 8'h02, 32'hFFFFFFFF, 32'h0, 8'd5},   // R5 enable bits
    '{1'b1, 8'h02, 32'h0, 32'h15,       8'd5},
    '{1'b0, 8'h02, 32'h0, 32'h0,        8'd5},
    '{1'b0, 8'h10, 32'h04050607, 32'h0, 8'd9},   // R9 address words
    '{1'b1, 8'h10, 32'h0, 32'h04050607, 8'd9},
    '{1'b0, 8'h11, 32'hFFFF0203, 32'h0, 8'd9},
    '{1'b1, 8'h11, 32'h0, 32'h00000203, 8'd9},
    '{1'b0, 8'h06, 32'h00200400, 32'h0, 8'd7},   // R7 length
    '{1'b1, 8'h06, 32'h0, 32'h00200400, 8'd7},
    '{1'b0, 8'h01, 32'hFFFFFFFF, 32'h0, 8'd4},   // R4 clear on empty
    '{1'b1, 8'h01, 32'h0, 32'h0,        8'd4}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic pulse(input logic tx, input logic rx, input logic drop);
    @(negedge clk);
    evTxDone = tx; evRxDone = rx; evRxDrop = drop;
    @(negedge clk);
    evTxDone = 1'b0; evRxDone = 1'b0; evRxDrop = 1'b0;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq", irqOut, 1'b0);
    check("R1 enables", {macSoftRst, promiscOn, txEnable, rxEnable}, 4'b0000);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].isRead) begin
        busRead(VECS[k].addr, rd);
        check($sformatf("R%0d vec %0d", VECS[k].req, k), rd, VECS[k].exp);
      end else begin
        busWrite(VECS[k].addr, VECS[k].data);
      end
    end

    // R12: data only in the cycle after the strobe
    busRead(8'h12, rd);
    check("R12 data", rd, 32'hDEADBEEF);
    @(negedge clk);
    check("R12 idle", busRdata, 32'h0);

    // R2, R7, R9: decoded outputs
    busWrite(8'h00, 32'h0000_0023);
    check("R2 outputs", {macSoftRst, promiscOn, txEnable, rxEnable}, 4'b0111);
    busWrite(8'h00, 32'h0000_0002);
    check("R2 tx only", {macSoftRst, promiscOn, txEnable, rxEnable}, 4'b0010);
    check("R7 lengths", {minFrameLen, maxFrameLen}, 32'h00200400);
    check("R9 station", stationAddr, 48'h0203_0405_0607);

    // R3: events set their bits, irq stays low with enables clear
    pulse(1, 0, 0);
    busRead(8'h01, rd);
    check("R3 tx flag", rd, 32'h01);
    pulse(0, 1, 1);
    busRead(8'h01, rd);
    check("R3 rx+drop flags", rd, 32'h15);
    check("R5 masked irq", irqOut, 1'b0);

    // R4: clear selected flag; event beats clear in same cycle
    busWrite(8'h01, 32'h04);
    busRead(8'h01, rd);
    check("R4 clear rx", rd, 32'h11);
    @(negedge clk);
    busAddr = 8'h01; busWdata = 32'h01; busWr = 1'b1; evTxDone = 1'b1;
    @(negedge clk);
    busWr = 1'b0; evTxDone = 1'b0;
    busRead(8'h01, rd);
    check("R4 event wins", rd, 32'h11);
    busWrite(8'h01, 32'h11);
    busRead(8'h01, rd);
    check("R4 all clear", rd, 32'h0);

    // R5: irq timing
    busWrite(8'h02, 32'h04);
    pulse(0, 1, 0);
    check("R5 irq not early", irqOut, 1'b0);
    @(negedge clk);
    check("R5 irq rise", irqOut, 1'b1);
    busWrite(8'h01, 32'h04);
    check("R5 irq still held", irqOut, 1'b1);
    @(negedge clk);
    check("R5 irq fall", irqOut, 1'b0);

    // R13: descriptor positions
    busWrite(8'h08, 32'd3);
    check("R13 tx start", txDescPtr, 8'd0);
    check("R13 rx start", rxDescPtr, 8'd3);
    pulse(1, 0, 0); check("R13 tx 1", txDescPtr, 8'd1);
    pulse(1, 0, 0); check("R13 tx 2", txDescPtr, 8'd2);
    pulse(1, 0, 0); check("R13 tx wrap", txDescPtr, 8'd0);
    pulse(0, 1, 0); check("R13 rx step", rxDescPtr, 8'd4);
    pulse(0, 0, 1); check("R13 drop no step", rxDescPtr, 8'd4);
    busWrite(8'h08, 32'd126);
    check("R13 rx reload", rxDescPtr, 8'd126);
    pulse(0, 1, 0); check("R13 rx 127", rxDescPtr, 8'd127);
    pulse(0, 1, 0); check("R13 rx wrap", rxDescPtr, 8'd126);
    busWrite(8'h08, 32'd128);
    pulse(0, 1, 0); check("R13 rx empty region", rxDescPtr, 8'd128);
    busWrite(8'h08, 32'd0);
    pulse(1, 0, 0); check("R13 tx empty region", txDescPtr, 8'd0);
    busWrite(8'h08, 32'd4);
    pulse(1, 0, 0); check("R13 tx before reset", txDescPtr, 8'd1);

    // R6: soft reset clears events and pointers, keeps configuration
    busWrite(8'h01, 32'hFF);
    busWrite(8'h02, 32'h15);
    pulse(1, 0, 0);
    @(negedge clk);
    check("R6 irq before", irqOut, 1'b1);
    busWrite(8'h00, 32'h0000_0823);
    check("R6 soft flag", macSoftRst, 1'b1);
    pulse(0, 1, 1);
    busRead(8'h01, rd);
    check("R6 flags held", rd, 32'h0);
    check("R6 tx ptr", txDescPtr, 8'd0);
    check("R6 rx ptr", rxDescPtr, 8'd4);
    check("R6 irq low", irqOut, 1'b0);
    busRead(8'h02, rd);
    check("R6 enable kept", rd, 32'h15);
    busRead(8'h06, rd);
    check("R6 length kept", rd, 32'h00200400);
    busRead(8'h00, rd);
    check("R6 mode kept", rd, 32'h0823);
    busWrite(8'h00, 32'h0000_0003);
    pulse(0, 1, 0);
    busRead(8'h01, rd);
    check("R6 events resume", rd, 32'h04);

    finishRun();
  end
endmodule